// File: doc/BRIEF.md
# Event-Action PWM Waveform Generator

This block produces one raw PWM level from events reported by a separate timer core. It does not compare a duty value. Each cycle, the timer core can report a zero hit, a reload hit, a compare-X hit and a compare-Y hit, together with the current counting direction. The block turns each of these hits into one of six directional events. The event's 2-bit field in a 12-bit action word then sets the output low, sets it high, toggles it, or leaves it alone.

The timer core and the compare registers are shared. A design that needs two independent channels instantiates the block twice. Each instance gets its own action word and its own enable, and both are fed from the same hit strobes. Dead time, polarity inversion and fault blanking belong to stages after this block.

Top module: `pwm_evact`

## Requirements
- R1: While the asynchronous active-low reset is asserted, `pwm_raw` is 0. It stays 0 until an enabled event action changes it.
- R2: While `chan_en` is 0, `pwm_raw` is 0 from the next clock edge onward and hit strobes have no effect. The stored level is also cleared: after re-enabling with no hits, the output stays 0.
- R3: A 2-bit action code means the following: 00 keeps the level, 01 drives it low, 10 drives it high, and 11 toggles it. The new level appears on `pwm_raw` at the first clock edge after the cycle in which the hit strobe is high.
- R4: In an enabled cycle with no hit strobe, `pwm_raw` keeps its value at the next edge.
- R5: The action word has fixed field positions. Bits [1:0] are zero, [3:2] are compare-X up, [5:4] are compare-Y up, [7:6] are reload, [9:8] are compare-Y down and [11:10] are compare-X down.
- R6: A compare hit with `cnt_up`=1 uses only its up field, and with `cnt_up`=0 uses only its down field. Zero and reload hits do not depend on `cnt_up`.
- R7: When hits coincide, their actions are applied one after another, each to the result of the one before. The order is zero, then reload, then the compares in counting order. Counting up, compare-X comes before compare-Y. Counting down, compare-Y comes before compare-X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable; 0 holds output and state low |
| act_cfg | input | 12 | Six 2-bit action fields |
| cnt_up | input | 1 | Counting direction of the timer core, 1 = up |
| hit_zero | input | 1 | Counter equals zero this tick |
| hit_reload | input | 1 | Counter equals reload value this tick |
| hit_cmpx | input | 1 | Counter equals compare X this tick |
| hit_cmpy | input | 1 | Counter equals compare Y this tick |
| pwm_raw | output | 1 | Registered raw PWM level |

## Verification
The assertions assume that the hit strobes are valid for exactly one cycle per timer tick and that `cnt_up` and `act_cfg` are stable in the cycles those strobes are sampled. The bench meets this by changing all inputs together at the falling clock edge, one tick per cycle. Coincident hits that a real counter can produce, such as zero together with compare, are generated on purpose. The randomized phase may also raise combinations that a real counter never raises. The reference model handles these with the same ordering rule, so they stay within what the properties cover.

// File: rtl/pwm_evact_pkg.sv
package pwm_evact_pkg;

   localparam int unsigned ACT_W   = 2;
   localparam int unsigned NUM_EVT = 6;
   localparam int unsigned CFG_W   = ACT_W * NUM_EVT;

   // slot positions inside the action word (behavioural: decoded by field)
   localparam int unsigned SLOT_ZERO = 0;
   localparam int unsigned SLOT_XUP  = 1;
   localparam int unsigned SLOT_YUP  = 2;
   localparam int unsigned SLOT_REL  = 3;
   localparam int unsigned SLOT_YDN  = 4;
   localparam int unsigned SLOT_XDN  = 5;

   typedef enum logic [ACT_W-1:0] {
      ACT_KEEP = 2'b00,
      ACT_LOW  = 2'b01,
      ACT_HIGH = 2'b10,
      ACT_FLIP = 2'b11
   } act_e;

   // application order: step index -> slot
   function automatic int unsigned step_slot(input int unsigned step);
      case (step)
         0:       step_slot = SLOT_ZERO;
         1:       step_slot = SLOT_REL;
         2:       step_slot = SLOT_XUP;
         3:       step_slot = SLOT_YUP;
         4:       step_slot = SLOT_YDN;
         default: step_slot = SLOT_XDN;
      endcase
   endfunction

   function automatic logic apply_act(input logic lvl, input act_e act);
      case (act)
         ACT_LOW:  apply_act = 1'b0;
         ACT_HIGH: apply_act = 1'b1;
         ACT_FLIP: apply_act = ~lvl;
         default:  apply_act = lvl;
      endcase
   endfunction

endpackage

// File: rtl/pwm_evact_evdec.sv
module pwm_evact_evdec
   import pwm_evact_pkg::*;
#(
   parameter int unsigned N_EVT = NUM_EVT
)(
   input  logic             cnt_up,
   input  logic             hit_zero,
   input  logic             hit_reload,
   input  logic             hit_cmpx,
   input  logic             hit_cmpy,
   output logic [N_EVT-1:0] evt_vec
);

   generate
      if (N_EVT != 6) begin : g_bad_n
         $error("pwm_evact_evdec: exactly six event slots are supported");
      end
   endgenerate

   always_comb begin
      evt_vec            = '0;
      evt_vec[SLOT_ZERO] = hit_zero;
      evt_vec[SLOT_REL]  = hit_reload;
      evt_vec[SLOT_XUP]  = hit_cmpx &  cnt_up;
      evt_vec[SLOT_YUP]  = hit_cmpy &  cnt_up;
      evt_vec[SLOT_YDN]  = hit_cmpy & ~cnt_up;
      evt_vec[SLOT_XDN]  = hit_cmpx & ~cnt_up;
   end

endmodule

// File: rtl/pwm_evact_resolve.sv
module pwm_evact_resolve
   import pwm_evact_pkg::*;
#(
   parameter int unsigned N_EVT = NUM_EVT,
   parameter int unsigned A_W   = ACT_W,
   localparam int unsigned C_W  = N_EVT * A_W
)(
   input  logic             lvl_q,
   input  logic [N_EVT-1:0] evt_vec,
   input  logic [C_W-1:0]   act_cfg,
   output logic             lvl_d
);

   generate
      if (A_W != 2) begin : g_bad_w
         $error("pwm_evact_resolve: action fields must be 2 bits");
      end
   endgenerate

   logic [N_EVT:0] chain;
   assign chain[0] = lvl_q;

   genvar s;
   generate
      for (s = 0; s < N_EVT; s++) begin : g_step
         localparam int unsigned SL = step_slot(s);
         act_e act;
         assign act = act_e'(act_cfg[SL*A_W +: A_W]);
         assign chain[s+1] = evt_vec[SL] ? apply_act(chain[s], act) : chain[s];
      end
   endgenerate

   assign lvl_d = chain[N_EVT];

endmodule

// File: rtl/pwm_evact_outreg.sv
module pwm_evact_outreg (
   input  logic clk,
   input  logic rst_n,
   input  logic chan_en,
   input  logic lvl_d,
   output logic lvl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lvl_q <= 1'b0;
      else if (!chan_en) lvl_q <= 1'b0;
      else               lvl_q <= lvl_d;
   end

   // R2
   low_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !lvl_q);

endmodule

// File: rtl/pwm_evact.sv
module pwm_evact
   import pwm_evact_pkg::*;
#(
   parameter int unsigned EVT_CNT = NUM_EVT,
   parameter int unsigned FLD_W   = ACT_W,
   localparam int unsigned CW     = EVT_CNT * FLD_W
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chan_en,
   input  logic [CW-1:0] act_cfg,
   input  logic          cnt_up,
   input  logic          hit_zero,
   input  logic          hit_reload,
   input  logic          hit_cmpx,
   input  logic          hit_cmpy,
   output logic          pwm_raw
);

   logic [EVT_CNT-1:0] evt_vec;
   logic               lvl_d;
   logic               lvl_q;

   pwm_evact_evdec #(.N_EVT(EVT_CNT)) u_evdec (
      .cnt_up(cnt_up), .hit_zero(hit_zero), .hit_reload(hit_reload),
      .hit_cmpx(hit_cmpx), .hit_cmpy(hit_cmpy), .evt_vec(evt_vec)
   );

   pwm_evact_resolve #(.N_EVT(EVT_CNT), .A_W(FLD_W)) u_resolve (
      .lvl_q(lvl_q), .evt_vec(evt_vec), .act_cfg(act_cfg), .lvl_d(lvl_d)
   );

   pwm_evact_outreg u_outreg (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .lvl_d(lvl_d), .lvl_q(lvl_q)
   );

   assign pwm_raw = lvl_q;

   logic any_hit;
   assign any_hit = hit_zero | hit_reload | hit_cmpx | hit_cmpy;

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && !any_hit) |=> (pwm_raw == $past(pwm_raw)));

   // R3
   zero_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && hit_zero && !hit_reload && !hit_cmpx && !hit_cmpy
       && act_cfg[1:0] == 2'b10) |=> pwm_raw);

   // R3
   zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && hit_zero && !hit_reload && !hit_cmpx && !hit_cmpy
       && act_cfg[1:0] == 2'b01) |=> !pwm_raw);

   // R5
   reload_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && hit_reload && !hit_zero && !hit_cmpx && !hit_cmpy
       && act_cfg[7:6] == 2'b11) |=> (pwm_raw != $past(pwm_raw)));

   // R6
   xdown_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && !cnt_up && hit_cmpx && !hit_zero && !hit_reload && !hit_cmpy
       && act_cfg[11:10] == 2'b10) |=> pwm_raw);

endmodule

// File: tb/pwm_evact_bench.sv
`timescale 1ns/1ps
module pwm_evact_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b0;
   logic [11:0] act_cfg = '0;
   logic        cnt_up = 1'b1;
   logic        hit_zero = 1'b0, hit_reload = 1'b0, hit_cmpx = 1'b0, hit_cmpy = 1'b0;
   logic        pwm_raw;

   int total = 0;
   int bad   = 0;
   logic model_lvl = 1'b0;
   bit   exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   pwm_evact u_pwm_evact (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .act_cfg(act_cfg),
      .cnt_up(cnt_up), .hit_zero(hit_zero), .hit_reload(hit_reload),
      .hit_cmpx(hit_cmpx), .hit_cmpy(hit_cmpy), .pwm_raw(pwm_raw)
   );

   function automatic logic act(input logic l, input logic [1:0] c);
      case (c)
         2'b01:   return 1'b0;
         2'b10:   return 1'b1;
         2'b11:   return ~l;
         default: return l;
      endcase
   endfunction

   // R7 reference: zero, reload, then compares in counting order
   function automatic logic model(input logic l, input logic [11:0] c, input logic up,
                                  input logic z, input logic r, input logic x, input logic y);
      logic v;
      v = l;
      if (z) v = act(v, c[1:0]);
      if (r) v = act(v, c[7:6]);
      if (up) begin
         if (x) v = act(v, c[3:2]);
         if (y) v = act(v, c[5:4]);
      end else begin
         if (y) v = act(v, c[9:8]);
         if (x) v = act(v, c[11:10]);
      end
      return v;
   endfunction

   task automatic step(input logic en, input logic [11:0] c, input logic up,
                       input logic z, input logic r, input logic x, input logic y,
                       input string tag);
      @(negedge clk);
      chan_en = en; act_cfg = c; cnt_up = up;
      hit_zero = z; hit_reload = r; hit_cmpx = x; hit_cmpy = y;
      model_lvl = en ? model(model_lvl, c, up, z, r, x, y) : 1'b0;
      exp_q.push_back(model_lvl);
      tag_q.push_back(tag);
   endtask

   task automatic check(input logic got, input logic exp, input string tag);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: pwm_raw=%0b expected=%0b", tag, got, exp);
      end
   endtask

   // monitor: sample away from the active edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) check(pwm_raw, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   initial begin
      #200000;
      bad++; total++;
      $display("FAIL watchdog: run hung");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(pwm_raw, 1'b0, "R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(pwm_raw, 1'b0, "R1 after reset");

      // R2: disabled, hits ignored
      step(0, 12'hAAA, 1, 1, 1, 1, 1, "R2 off ignores hits");
      // R3: actions on zero field
      step(1, 12'h002, 1, 1, 0, 0, 0, "R3 zero high");
      step(1, 12'h000, 1, 1, 0, 0, 0, "R3 zero keep");
      step(1, 12'h000, 1, 0, 0, 0, 0, "R4 idle hold high");
      step(1, 12'h003, 1, 1, 0, 0, 0, "R3 zero toggle");
      step(1, 12'h003, 1, 1, 0, 0, 0, "R3 zero toggle back");
      step(1, 12'h001, 1, 1, 0, 0, 0, "R3 zero low");
      // R5: each field in its place
      step(1, 12'h008, 1, 0, 0, 1, 0, "R5 xup high [3:2]");
      step(1, 12'h010, 1, 0, 0, 0, 1, "R5 yup low [5:4]");
      step(1, 12'h080, 1, 0, 1, 0, 0, "R5 reload high [7:6]");
      step(1, 12'h100, 0, 0, 0, 0, 1, "R5 ydn low [9:8]");
      step(1, 12'h800, 0, 1'b0, 0, 1, 0, "R5 xdn high [11:10]");
      // R6: direction selects field
      step(1, 12'h004, 0, 0, 0, 1, 0, "R6 xup field ignored when down");
      step(1, 12'h400, 1, 0, 0, 1, 0, "R6 xdn field ignored when up");
      step(1, 12'h040, 0, 0, 1, 0, 0, "R6 reload low either direction");
      // R7: coincidence ordering
      step(1, 12'h042, 1, 1, 1, 0, 0, "R7 zero high then reload low");
      step(1, 12'h0C2, 1, 1, 1, 0, 0, "R7 zero high then reload toggle");
      step(1, 12'h024, 1, 0, 0, 1, 1, "R7 up x low then y high");
      step(1, 12'h614, 0, 0, 0, 1, 1, "R7 down y high then x low");
      step(1, 12'h00E, 1, 1, 0, 1, 0, "R7 zero high then xup toggle");
      // R2: disable clears stored state
      step(1, 12'h002, 1, 1, 0, 0, 0, "R2 set high before off");
      step(0, 12'h002, 1, 0, 0, 0, 0, "R2 off drives low");
      step(1, 12'h002, 1, 0, 0, 0, 0, "R2 re-enable stays low");
      // mixed random ticks
      for (int i = 0; i < 300; i++) begin
         logic [3:0] h;
         h = 4'($urandom);
         step(($urandom % 8) != 0, 12'($urandom), 1'($urandom),
              h[0], h[1], h[2], h[3], "R7 random mix");
      end
      step(1, 12'h000, 1, 0, 0, 0, 0, "R4 final idle");
      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule